// File: doc/BRIEF.md
# Robbed-bit signaling writeover unit

This block carries one 64 kbit/s channel from an incoming T1 stream to an outgoing T1 stream whose frame and superframe phases have no fixed relation to each other. Each incoming byte arrives with its frame number inside the incoming superframe. Each outgoing frame slot is requested by a strobe that carries the outgoing frame number. A format select chooses the 12-frame superframe (SF) or the 24-frame extended superframe (ESF).

The byte path holds data for no more than one frame. Each byte goes into the next outgoing slot, whatever the superframe alignment. Signaling takes a separate path. When an incoming byte falls in a signaling frame, its least significant bit is stored as the current state of that frame's signaling letter. When an outgoing slot falls in a signaling frame, the least significant bit of the outgoing byte is overwritten with the stored state of the letter that matches the outgoing phase. That data bit is lost on purpose.

Top module: `rbw_writeover_top`

## Requirements
- R1: After reset `out_valid_o` is 0, `out_byte_o` is 0, every stored signaling state is 0 and the held byte is 0.
- R2: With `esf_mode_i`=0, frames are numbered 1..12. Frame 6 carries letter A and frame 12 carries letter B.
- R3: With `esf_mode_i`=1, frames are numbered 1..24. Frames 6, 12, 18 and 24 carry letters A, B, C and D.
- R4: The signaling bit is bit 8 of the channel byte, which is bit 0 (the LSB) of the 8-bit byte ports. Bit 7 of a port is bit 1 of the channel byte.
- R5: When `in_valid_i` is high in a signaling frame, `in_byte_i[0]` becomes that letter's state. Bytes in other frames leave all states unchanged.
- R6: For a strobe in an outgoing signaling frame, `out_byte_o[0]` equals the stored state of that frame's letter.
- R7: For a strobe in an outgoing non-signaling frame, `out_byte_o[0]` equals bit 0 of the outgoing data byte, even if that bit was signaling on the incoming side.
- R8: `out_byte_o[7:1]` always equals bits 7:1 of the outgoing data byte.
- R9: The outgoing data byte is `in_byte_i` when `in_valid_i` is high in the strobe cycle, and otherwise the last accepted incoming byte. The result appears in the cycle after the strobe.
- R10: `out_valid_o` is high for exactly the one cycle after each `out_strobe_i`, and low at all other times.
- R11: If a capture and a writeover of the same letter fall in the same cycle, the captured value is written out.
- R12: In SF mode, frames 18 and 24 are not signaling frames, and their bit 0 passes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| esf_mode_i | input | 1 | 1 = 24-frame superframe, 0 = 12-frame superframe |
| in_valid_i | input | 1 | Incoming byte present this cycle |
| in_byte_i | input | 8 | Incoming channel byte, bit 0 = signaling bit position |
| in_frame_i | input | 5 | Incoming frame number within its superframe (1-based) |
| out_strobe_i | input | 1 | Outgoing frame slot request |
| out_frame_i | input | 5 | Outgoing frame number within its superframe (1-based) |
| out_valid_o | output | 1 | Outgoing byte valid, one cycle after the strobe |
| out_byte_o | output | 8 | Outgoing channel byte |

## Verification
Two things can land in one cycle: an incoming signaling frame capturing a letter, and an outgoing strobe overwriting the same letter. A byte can also arrive in the same cycle as the strobe that carries it out. Directed steps put incoming frame 6 and outgoing frame 6 in one cycle, first with bit 0 set and then cleared. Random traffic with independent frame counters and random gaps causes many more such collisions. In each case the bench model applies the capture before the writeover, and the bench compares bit 0 and bits 7:1 of the output separately against that model.

// File: rtl/rbw_pkg.sv
package rbw_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned FRAME_W    = 5;
  localparam int unsigned N_LETTERS  = 4;
  localparam int unsigned SIG_PERIOD = 6;
  localparam int unsigned SF_LEN     = 12;
  localparam int unsigned ESF_LEN    = 24;
  localparam int unsigned LETTER_W   = $clog2(N_LETTERS);
  typedef logic [LETTER_W-1:0] letter_t;
endpackage

// File: rtl/rbw_frame_decode.sv
module rbw_frame_decode
  import rbw_pkg::*;
(
  input  logic               esf_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               is_sig_o,
  output letter_t            letter_o
);
  logic [FRAME_W-1:0] len, rem, quo;

  always_comb begin
    len      = esf_i ? FRAME_W'(ESF_LEN) : FRAME_W'(SF_LEN);
    rem      = frame_i % FRAME_W'(SIG_PERIOD);
    quo      = frame_i / FRAME_W'(SIG_PERIOD);
    is_sig_o = (frame_i != '0) && (frame_i <= len) && (rem == '0);
    letter_o = is_sig_o ? LETTER_W'(quo - FRAME_W'(1)) : '0;
  end
endmodule

// File: rtl/rbw_sig_store.sv
module rbw_sig_store
  import rbw_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    cap_en_i,
  input  letter_t cap_letter_i,
  input  logic    cap_bit_i,
  input  letter_t rd_letter_i,
  output logic    rd_bit_o
);
  logic [N_LETTERS-1:0] state_q, state_d;

  for (genvar i = 0; i < N_LETTERS; i++) begin : g_letter
    assign state_d[i] = (cap_en_i && cap_letter_i == letter_t'(i)) ? cap_bit_i : state_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= '0;
    else         state_q <= state_d;
  end

  // a capture in this cycle wins over the stored state
  assign rd_bit_o = (cap_en_i && cap_letter_i == rd_letter_i) ? cap_bit_i : state_q[rd_letter_i];

  AST_CAPTURE_STORES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_en_i |=> state_q[$past(cap_letter_i)] == $past(cap_bit_i)); // R5
  AST_STATE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_en_i |=> $stable(state_q)); // R5
endmodule

// File: rtl/rbw_byte_hold.sv
module rbw_byte_hold
  import rbw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [BYTE_W-1:0] in_byte_i,
  output logic [BYTE_W-1:0] cur_byte_o
);
  logic [BYTE_W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         hold_q <= '0;
    else if (in_valid_i) hold_q <= in_byte_i;
  end

  assign cur_byte_o = in_valid_i ? in_byte_i : hold_q;

  AST_HOLD_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(hold_q)); // R9
endmodule

// File: rtl/rbw_writeover_top.sv
module rbw_writeover_top
  import rbw_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               esf_mode_i,
  input  logic               in_valid_i,
  input  logic [BYTE_W-1:0]  in_byte_i,
  input  logic [FRAME_W-1:0] in_frame_i,
  input  logic               out_strobe_i,
  input  logic [FRAME_W-1:0] out_frame_i,
  output logic               out_valid_o,
  output logic [BYTE_W-1:0]  out_byte_o
);
  logic              in_is_sig, out_is_sig, sig_bit;
  letter_t           in_letter, out_letter;
  logic [BYTE_W-1:0] cur_byte;

  rbw_frame_decode u_in_dec (
    .esf_i(esf_mode_i), .frame_i(in_frame_i), .is_sig_o(in_is_sig), .letter_o(in_letter));
  rbw_frame_decode u_out_dec (
    .esf_i(esf_mode_i), .frame_i(out_frame_i), .is_sig_o(out_is_sig), .letter_o(out_letter));

  rbw_sig_store u_sig (
    .clk_i, .rst_ni,
    .cap_en_i(in_valid_i && in_is_sig), .cap_letter_i(in_letter), .cap_bit_i(in_byte_i[0]),
    .rd_letter_i(out_letter), .rd_bit_o(sig_bit));

  rbw_byte_hold u_hold (
    .clk_i, .rst_ni, .in_valid_i, .in_byte_i, .cur_byte_o(cur_byte));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_byte_o  <= '0;
    end else begin
      out_valid_o <= out_strobe_i;
      if (out_strobe_i) out_byte_o <= {cur_byte[BYTE_W-1:1], out_is_sig ? sig_bit : cur_byte[0]};
    end
  end

  AST_VALID_AFTER_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_strobe_i |=> out_valid_o); // R10
  AST_NO_STRAY_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_strobe_i |=> !out_valid_o); // R10
  AST_UPPER_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_strobe_i |=> out_byte_o[BYTE_W-1:1] == $past(cur_byte[BYTE_W-1:1])); // R8
  AST_NONSIG_LSB_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_strobe_i && !out_is_sig |=> out_byte_o[0] == $past(cur_byte[0])); // R7
  AST_SIG_LSB_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_strobe_i && out_is_sig |=> out_byte_o[0] == $past(sig_bit)); // R6
endmodule

// File: tb/tb_rbw_writeover_top.sv
module tb_rbw_writeover_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       esf = 1'b0;
  logic       iv = 1'b0;
  logic [7:0] ib = '0;
  logic [4:0] ifr = '0;
  logic       os = 1'b0;
  logic [4:0] ofr = '0;
  logic       ov;
  logic [7:0] ob;

  int checks = 0, errors = 0;
  logic [7:0] ref_hold = '0;
  logic [3:0] ref_sig = '0;

  always #10 clk = ~clk;

  rbw_writeover_top dut (
    .clk_i(clk), .rst_ni(rst_n), .esf_mode_i(esf),
    .in_valid_i(iv), .in_byte_i(ib), .in_frame_i(ifr),
    .out_strobe_i(os), .out_frame_i(ofr),
    .out_valid_o(ov), .out_byte_o(ob));

  // letter index from frame number: -1 when not a signaling frame (R2, R3, R12)
  function automatic int letter_of(bit m, int fr);
    int len = m ? 24 : 12;
    if (fr < 1 || fr > len || fr % 6 != 0) return -1;
    return fr / 6 - 1;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check 1 ns after the following posedge
  task automatic step(bit v, logic [7:0] b, int f_in, bit s, int f_out, string tag);
    logic [7:0] cur;
    int il, ol;
    bit exp_lsb;
    @(negedge clk);
    iv = v; ib = b; ifr = 5'(f_in); os = s; ofr = 5'(f_out);
    cur = v ? b : ref_hold;                         // R9
    il = letter_of(esf, f_in);
    if (v && il >= 0) ref_sig[il] = b[0];           // R5, capture before writeover (R11)
    ol = letter_of(esf, f_out);
    exp_lsb = (ol >= 0) ? ref_sig[ol] : cur[0];     // R4: bit 8 is port bit 0
    if (v) ref_hold = b;
    @(posedge clk); #1;
    check("R10", int'(ov), int'(s));
    if (s) begin
      check("R8", int'(ob[7:1]), int'(cur[7:1]));
      check(tag != "" ? tag : (ol >= 0 ? "R6" : "R7"), int'(ob[0]), int'(exp_lsb));
    end
    iv = 1'b0; os = 1'b0;
  endtask

  initial begin : watchdog
    #3_000_000;
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    #1;
    check("R1", int'(ov), 0);
    check("R1", int'(ob), 0);
    rst_n = 1'b1;
    // R1: stored states zero, held byte zero
    esf = 1'b1;
    step(0, 8'h00, 0, 1, 12, "R1");
    step(0, 8'h00, 0, 1, 24, "R1");
    // R2: SF letters A and B
    esf = 1'b0;
    step(1, 8'h55, 6, 0, 0, "");
    step(1, 8'hAA, 12, 0, 0, "");
    step(0, 8'h00, 0, 1, 12, "R2");
    step(0, 8'h00, 0, 1, 6, "R2");
    // R12: frames 18/24 are data in SF
    step(1, 8'h13, 5, 0, 0, "");
    step(0, 8'h00, 0, 1, 18, "R12");
    step(0, 8'h00, 0, 1, 24, "R12");
    // R3: ESF letters C and D
    esf = 1'b1;
    step(1, 8'h31, 18, 0, 0, "");
    step(1, 8'h40, 24, 0, 0, "");
    step(0, 8'h00, 0, 1, 18, "R3");
    step(0, 8'h00, 0, 1, 24, "R3");
    // R5: non-signaling frame does not touch state A
    step(1, 8'h00, 6, 0, 0, "");
    step(1, 8'hFF, 7, 0, 0, "");
    step(0, 8'h00, 0, 1, 6, "R5");
    // R7: incoming signaling bit lands in a data frame unchanged
    step(1, 8'h81, 12, 1, 3, "R7");
    // R11: capture and writeover of letter A in one cycle
    step(1, 8'h01, 6, 1, 6, "R11");
    step(1, 8'hFE, 6, 1, 6, "R11");
    // R9: same-cycle byte and held byte
    step(1, 8'h5C, 2, 1, 2, "R9");
    step(0, 8'h00, 0, 1, 4, "R9");
    // random traffic, independent phases (R4..R11)
    for (int blk = 0; blk < 8; blk++) begin
      int len, fi, fo;
      esf = blk[0];
      len = esf ? 24 : 12;
      fi = 1 + int'($urandom % len);
      fo = 1 + int'($urandom % len);
      for (int n = 0; n < 600; n++) begin
        bit v = ($urandom % 3) == 0;
        bit s = ($urandom % 3) == 0;
        step(v, 8'($urandom), fi, s, fo, "");
        if (v) fi = fi % len + 1;
        if (s) fo = fo % len + 1;
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule